// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a watchdog timer. A down-counter is advanced by a count strobe. Software programs a timeout value, enables the block, and reloads the counter to show that it is still alive. In the default two-stage mode, the first time the count runs out the block raises a pending flag that drives an interrupt, and it starts a new period. If software has not acknowledged that flag by the time the next period also runs out, the block requests a system reset.

A mode input selects a one-stage variant instead. In that mode the first timeout goes straight to the reset request. The reset request is a registered pulse of fixed length. When it fires, the block also clears its own run bit, so it stays idle until software restarts it.

Software reaches the block through a flat register port with four word slots. The slots hold the timeout, show the live count, carry the control bits, and provide an acknowledge that also restarts the period.

Top module: `dual_phase_wdog`

## Requirements
- R1: After reset, the timeout register and the count both read 0xFFFFFFFF, the control register reads 0, and both irq_o and sys_rst_o are low.
- R2: Byte address 0x0 is the timeout register (read and write). 0x4 returns the live count. 0x8 is control, with bit0 = run, bit1 = interrupt enable and bit2 = reset enable; it reads back in those positions. A write of any data to 0xC is an acknowledge.
- R3: The count decrements by one on each clock where tick is high and run is set. It holds while run is clear or tick is low.
- R4: A tick that finds the count at 1 or 0 while running is an expiry. On that edge the count reloads from the timeout register.
- R5: Writing 0x0 loads the written value into both the timeout register and the count. An acknowledge reloads the count from the timeout register. A bus reload takes priority over a tick in the same cycle.
- R6: In two-stage mode an expiry sets the pending flag. irq_o is high while pending and interrupt enable are both set.
- R7: An acknowledge clears the pending flag, so irq_o is low in the next cycle.
- R8: An expiry that finds the flag already pending, with reset enable set, drives sys_rst_o high for exactly 4 cycles, starting the cycle after that edge.
- R9: With reset enable clear, a second expiry raises no reset. The flag stays pending and counting continues.
- R10: With interrupt enable clear, irq_o stays low, but the pending flag is still set and escalation to reset still happens.
- R11: With single_phase high, an expiry with reset enable set fires the reset directly. The pending flag and irq_o never rise.
- R12: When the reset fires, the run bit and the pending flag clear, and the count then holds until run is written again.
- R13: A write to the count slot (0x4) changes neither the count nor the timeout register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count strobe, one decrement per high cycle |
| single_phase | input | 1 | High selects the one-stage mode |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address of the register slot |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Interrupt, pending flag gated by interrupt enable |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
The bench issues a timeout write in the same cycle as a tick. A design that let the tick win would show the old count minus one. It runs escalation with the interrupt masked; a design that gated the pending flag with the enable would never reach reset. It also checks the exact pulse width and that the counter is frozen after a fire, which catches pulses that are off by one and counters that restart by themselves. The one-stage run and the run with reset disabled show whether the design wrongly raises the interrupt or wrongly resets.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        SLOT_TIMEOUT = 2'd0,
        SLOT_COUNT   = 2'd1,
        SLOT_CTRL    = 2'd2,
        SLOT_ACK     = 2'd3
    } slot_e;

    typedef struct packed {
        logic rst_on;
        logic irq_on;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int W = 32,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         reload,
    input  logic [W-1:0] reload_val,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         expire
);
    typedef struct packed {
        logic [W-1:0] count;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       step_now;

    always_comb begin
        s_d      = s_q;
        step_now = run && tick && !reload;
        expire   = step_now && (s_q.count <= W'(1));
        if (reload) begin
            s_d.count = reload_val;
        end else if (expire) begin
            s_d.count = load_val;
        end else if (step_now) begin
            s_d.count = s_q.count - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.count <= INIT;
        else        s_q <= s_d;
    end

    assign count = s_q.count;

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !reload && s_q.count > W'(1)) |=> s_q.count == $past(s_q.count) - W'(1));
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload) |=> $stable(s_q.count));
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> s_q.count == $past(load_val));
    p_kick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> s_q.count == $past(reload_val));
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate #(
    parameter int PULSE = 4,
    localparam int CW = $clog2(PULSE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr,
    input  logic single_phase,
    input  logic irq_on,
    input  logic rst_on,
    output logic irq_o,
    output logic sys_rst_o,
    output logic fire
);
    typedef struct packed {
        logic          pending;
        logic [CW-1:0] pcnt;
    } esc_state_t;

    esc_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        fire = expire && rst_on && (single_phase || s_q.pending);
        if (clr || fire) begin
            s_d.pending = 1'b0;
        end else if (expire && !single_phase) begin
            s_d.pending = 1'b1;
        end
        if (fire) begin
            s_d.pcnt = CW'(PULSE);
        end else if (s_q.pcnt != '0) begin
            s_d.pcnt = s_q.pcnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_o     = s_q.pending && irq_on;
    assign sys_rst_o = (s_q.pcnt != '0);

    p_pending_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.pending) |-> $past(expire && !single_phase));
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !s_q.pending);
    p_fire_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> sys_rst_o);
    p_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && single_phase && rst_on) |=> sys_rst_o && !s_q.pending);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int W = 32,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [3:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] count,
    input  logic         fire,
    output logic [W-1:0] rdata,
    output ctrl_t        ctrl,
    output logic [W-1:0] load_val,
    output logic         reload,
    output logic [W-1:0] reload_val,
    output logic         clr
);
    typedef struct packed {
        logic [W-1:0] load;
        ctrl_t        ctrl;
    } reg_state_t;

    reg_state_t s_d, s_q;
    slot_e      slot;
    logic       unused_bits;

    assign slot        = slot_e'(addr[3:2]);
    assign unused_bits = ^{addr[1:0], wdata[W-1:3]};

    always_comb begin
        s_d        = s_q;
        reload     = 1'b0;
        clr        = 1'b0;
        reload_val = s_q.load;
        if (wr) begin
            unique case (slot)
                SLOT_TIMEOUT: begin
                    s_d.load   = wdata;
                    reload     = 1'b1;
                    reload_val = wdata;
                end
                SLOT_CTRL: s_d.ctrl = ctrl_t'(wdata[2:0]);
                SLOT_ACK: begin
                    clr    = 1'b1;
                    reload = 1'b1;
                end
                default: ;
            endcase
        end
        if (fire) s_d.ctrl.run = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.load <= INIT;
            s_q.ctrl <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (slot)
            SLOT_TIMEOUT: rdata = s_q.load;
            SLOT_COUNT:   rdata = count;
            SLOT_CTRL:    rdata = {{(W-3){1'b0}}, s_q.ctrl};
            default:      rdata = '0;
        endcase
    end

    assign ctrl     = s_q.ctrl;
    assign load_val = s_q.load;

    p_run_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !s_q.ctrl.run);
    p_count_ro_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && slot == SLOT_COUNT) |=> $stable(s_q.load));
endmodule

// File: rtl/dual_phase_wdog.sv
module dual_phase_wdog
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter logic [CNT_W-1:0] RESET_LOAD = '1,
    parameter int RST_PULSE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             single_phase,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq_o,
    output logic             sys_rst_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_val, reload_val, count;
    logic             reload, clr, expire, fire;

    wdog_regs #(.W(CNT_W), .INIT(RESET_LOAD)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .count(count), .fire(fire), .rdata(bus_rdata),
        .ctrl(ctrl), .load_val(load_val), .reload(reload),
        .reload_val(reload_val), .clr(clr)
    );

    wdog_counter #(.W(CNT_W), .INIT(RESET_LOAD)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(tick),
        .reload(reload), .reload_val(reload_val), .load_val(load_val),
        .count(count), .expire(expire)
    );

    wdog_escalate #(.PULSE(RST_PULSE)) u_esc (
        .clk(clk), .rst_n(rst_n), .expire(expire), .clr(clr),
        .single_phase(single_phase), .irq_on(ctrl.irq_on),
        .rst_on(ctrl.rst_on), .irq_o(irq_o), .sys_rst_o(sys_rst_o),
        .fire(fire)
    );
endmodule

// File: tb/dual_phase_wdog_test.sv
`timescale 1ns/1ps
module dual_phase_wdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        single_phase = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq_o, sys_rst_o;

    always #2.5 clk = ~clk;

    dual_phase_wdog uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .single_phase(single_phase),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    typedef struct {
        int          due;
        int          kind;
        logic [31:0] exp;
        string       req;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare every queued expectation due in this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                logic [31:0] act;
                case (sb[i].kind)
                    0:       act = bus_rdata;
                    1:       act = {31'b0, irq_o};
                    default: act = {31'b0, sys_rst_o};
                endcase
                n_chk++;
                if (act !== sb[i].exp) begin
                    n_fail++;
                    $display("FAIL %s kind%0d actual=%h expected=%h", sb[i].req, sb[i].kind, act, sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_at(input int kind, input int delay, input logic [31:0] e, input string r);
        exp_t it;
        it.due = cyc + delay; it.kind = kind; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string r);
        bus_addr = a;
        expect_at(0, 0, e, r);
        step();
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) step();
        tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            n_chk += sb.size();
            n_fail += sb.size();
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        expect_at(1, 0, 0, "R1"); expect_at(2, 0, 0, "R1");
        rd(4'h0, 32'hFFFF_FFFF, "R1");
        rd(4'h4, 32'hFFFF_FFFF, "R1");
        rd(4'h8, 32'h0, "R1");
        // R3 no counting while run clear
        ticks(5);
        rd(4'h4, 32'hFFFF_FFFF, "R3");
        // R5 / R2 timeout write, R13 count slot read-only
        wr(4'h0, 32'd10);
        rd(4'h4, 32'd10, "R5");
        rd(4'h0, 32'd10, "R2");
        wr(4'h4, 32'd5);
        rd(4'h4, 32'd10, "R13");
        rd(4'h0, 32'd10, "R13");
        // R3 counting
        wr(4'h8, 32'h1);
        rd(4'h8, 32'h1, "R2");
        ticks(4);
        rd(4'h4, 32'd6, "R3");
        repeat (3) step();
        rd(4'h4, 32'd6, "R3");
        // R5 bus write beats tick
        tick = 1'b1;
        wr(4'h0, 32'd20);
        tick = 1'b0;
        rd(4'h4, 32'd20, "R5");
        ticks(2);
        rd(4'h4, 32'd18, "R3");
        wr(4'hC, 32'h0);
        rd(4'h4, 32'd20, "R5");
        // R6 / R4 first expiry
        wr(4'h8, 32'h3);
        wr(4'h0, 32'd3);
        ticks(3);
        expect_at(1, 0, 1, "R6");
        rd(4'h4, 32'd3, "R4");
        wr(4'hC, 32'h0);
        expect_at(1, 0, 0, "R7");
        expect_at(2, 0, 0, "R7");
        step();
        // R10 masked interrupt still escalates
        wr(4'h8, 32'h5);
        wr(4'h0, 32'd3);
        ticks(3);
        expect_at(1, 0, 0, "R10");
        wr(4'h8, 32'h7);
        expect_at(1, 0, 1, "R10");
        wr(4'h8, 32'h5);
        expect_at(2, 0, 0, "R8");
        ticks(3);
        // R8 pulse of 4 cycles
        expect_at(2, 0, 1, "R8");
        expect_at(2, 3, 1, "R8");
        expect_at(2, 4, 0, "R8");
        rd(4'h8, 32'h4, "R12");
        wr(4'h8, 32'h6);
        expect_at(1, 0, 0, "R12");
        ticks(5);
        rd(4'h4, 32'd3, "R12");
        // R9 reset disabled
        wr(4'h8, 32'h3);
        wr(4'h0, 32'd2);
        ticks(2);
        expect_at(1, 0, 1, "R9");
        ticks(2);
        expect_at(2, 0, 0, "R9");
        expect_at(1, 0, 1, "R9");
        rd(4'h4, 32'd2, "R9");
        ticks(1);
        rd(4'h4, 32'd1, "R9");
        wr(4'hC, 32'h0);
        // R11 single phase
        single_phase = 1'b1;
        wr(4'h8, 32'h7);
        wr(4'h0, 32'd2);
        ticks(2);
        expect_at(2, 0, 1, "R11");
        expect_at(1, 0, 0, "R11");
        repeat (5) step();
        expect_at(1, 0, 0, "R11");
        rd(4'h8, 32'h6, "R12");
        wr(4'h8, 32'h3);
        wr(4'h0, 32'd2);
        ticks(2);
        expect_at(2, 0, 0, "R11");
        expect_at(1, 0, 0, "R11");
        rd(4'h4, 32'd2, "R11");
        repeat (6) step();
        finish_run();
    end
endmodule